// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block collects interrupt requests from a parameterised number of maskable sources and decides which one, if any, the processor accepts. Each source owns a small control word made of a pending-request flag and a three-bit priority level. A combinational arbiter looks at every pending source whose level is strictly above the processor priority level. The arbiter runs only while the global enable flag is set. It picks the highest level, and on equal levels it picks the lowest source index.

A two-state machine registers the arbiter's choice. In `ST_IDLE` it waits for an eligible winner. When one appears it moves to `ST_GRANT`, where it raises `accept_o` and holds `acc_idx_o`. It stays in `ST_GRANT` until the processor pulses `ack_i` for the vector fetch. That acknowledge clears the chosen source's pending flag and takes the machine back to `ST_IDLE`. There are only two transitions: IDLE to GRANT on an eligible winner, and GRANT to IDLE on acknowledge.

Software reaches all state through a word-addressed write port and a combinational read port. Addresses 0 to N-1 select the source control words. Address N holds the global enable flag. Address N+1 holds the processor priority level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the global enable flag is 0, the processor priority level is 0, every source has level 0 with no pending request, and `accept_o` is 0.
- R2: A 1 on `irq_i[i]` at a clock edge sets source i's pending flag. The read data for address i shows it in bit 3 (bits 2:0 hold the level, upper bits read 0) right after that edge.
- R3: A write to address i with data bit 3 equal to 0 clears source i's pending flag. A write with bit 3 equal to 1 leaves the flag unchanged and never sets it. Data bits 2:0 load the level.
- R4: When a hardware request and a software clear hit the same source on the same edge, the flag ends up set.
- R5: No source is accepted while the global enable flag (address N, bit 0) is 0.
- R6: A source is accepted only if its level is strictly greater than the processor priority level (address N+1, bits 2:0). Level 0 is therefore never accepted, and a priority level of 7 blocks every source.
- R7: Among eligible sources the highest level wins. On equal levels the lowest index wins.
- R8: In `ST_IDLE`, an eligible winner present before a clock edge makes `accept_o` 1 and `acc_idx_o` equal that source after the edge. Both then stay unchanged until an acknowledge, whatever the other inputs do.
- R9: `ack_i` while `accept_o` is 1 clears the accepted source's pending flag and drops `accept_o` on the same edge. `ack_i` while `accept_o` is 0 has no effect.
- R10: The enable flag, the priority level and each source's control word are separate registers. Writing one never changes another.
- R11: A hardware request on the accepted source in the same cycle as its acknowledge leaves its pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N | Hardware request per source, sampled each edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address (0..N-1 sources, N enable, N+1 priority level) |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address, same map as writes |
| rd_data_o | output | DW | Combinational read data |
| accept_o | output | 1 | A source is accepted and awaits acknowledge |
| acc_idx_o | output | IW | Index of the accepted source |
| ack_i | input | 1 | Processor acknowledge of the vector fetch |

## Verification
A request on `irq_i` becomes a pending flag one edge later. It can then raise `accept_o` on the following edge, so acceptance lands on the second edge after the request. Register writes and acknowledges take effect on the very next edge, and a further acceptance can follow one edge after an acknowledge. The bench applies each stimulus at a falling edge and advances its reference model by exactly one rising edge. At the next falling edge it compares `accept_o`, `acc_idx_o` and the read data of the selected address, so every result is sampled in the cycle it is due.

// File: rtl/irqpc_pkg.sv
package irqpc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } irqpc_state_e;
endpackage

// File: rtl/irqpc_src_regs.sv
module irqpc_src_regs #(
    parameter int N     = 8,
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int IW    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              irq_i,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [DW-1:0]             wr_data_i,
    input  logic                      ack_clr_i,
    input  logic [IW-1:0]             ack_idx_i,
    output logic [N-1:0]              pend_o,
    output logic [N-1:0][LVL_W-1:0]   lvl_o
);
    localparam int PEND_BIT = LVL_W;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic hit;
        logic sw_clr;
        logic hw_clr;

        assign hit    = wr_en_i && (wr_addr_i == AW'(i));
        assign sw_clr = hit && !wr_data_i[PEND_BIT];
        assign hw_clr = ack_clr_i && (ack_idx_i == IW'(i));

        // hardware set is checked first so a coincident clear never loses it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[i] <= 1'b0;
            end else if (irq_i[i]) begin
                pend_o[i] <= 1'b1;
            end else if (sw_clr || hw_clr) begin
                pend_o[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_o[i] <= '0;
            end else if (hit) begin
                lvl_o[i] <= wr_data_i[LVL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irqpc_arbiter.sv
module irqpc_arbiter #(
    parameter int N     = 8,
    parameter int LVL_W = 3,
    parameter int IW    = 3
) (
    input  logic [N-1:0]            pend_i,
    input  logic [N-1:0][LVL_W-1:0] lvl_i,
    input  logic                    gie_i,
    input  logic [LVL_W-1:0]        ipl_i,
    output logic                    win_vld_o,
    output logic [IW-1:0]           win_idx_o,
    output logic [LVL_W-1:0]        win_lvl_o
);
    always_comb begin
        win_vld_o = 1'b0;
        win_idx_o = '0;
        win_lvl_o = '0;
        for (int i = 0; i < N; i++) begin
            // ascending scan with strict compare keeps the lowest index on ties
            if (gie_i && pend_i[i] && (lvl_i[i] > ipl_i) &&
                (!win_vld_o || (lvl_i[i] > win_lvl_o))) begin
                win_vld_o = 1'b1;
                win_idx_o = IW'(i);
                win_lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irqpc_fsm.sv
module irqpc_fsm
    import irqpc_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_vld_i,
    input  logic [IW-1:0] win_idx_i,
    input  logic          ack_i,
    output logic          accept_o,
    output logic [IW-1:0] idx_o,
    output logic          clr_o
);
    irqpc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_vld_i) state_d = ST_GRANT;
            ST_GRANT: if (ack_i)     state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (state_q == ST_IDLE && win_vld_i) begin
            idx_o <= win_idx_i;
        end
    end

    assign accept_o = (state_q == ST_GRANT);
    assign clr_o    = (state_q == ST_GRANT) && ack_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N     = 8,
    parameter int LVL_W = 3,
    parameter int DW    = 8,
    localparam int AW   = $clog2(N + 2),
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          accept_o,
    output logic [IW-1:0] acc_idx_o,
    input  logic          ack_i
);
    localparam logic [AW-1:0] A_GIE = AW'(N);
    localparam logic [AW-1:0] A_IPL = AW'(N + 1);

    logic                    gie_q;
    logic [LVL_W-1:0]        ipl_q;
    logic [N-1:0]            pend_q;
    logic [N-1:0][LVL_W-1:0] lvl_q;
    logic                    win_vld;
    logic [IW-1:0]           win_idx;
    logic [LVL_W-1:0]        win_lvl;
    logic                    ack_clr;

    if (DW > LVL_W + 1) begin : g_unused
        logic unused_wdata;
        assign unused_wdata = ^wr_data_i[DW-1:LVL_W+1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (wr_en_i && wr_addr_i == A_GIE) begin
            gie_q <= wr_data_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl_q <= '0;
        end else if (wr_en_i && wr_addr_i == A_IPL) begin
            ipl_q <= wr_data_i[LVL_W-1:0];
        end
    end

    irqpc_src_regs #(
        .N(N), .LVL_W(LVL_W), .DW(DW), .AW(AW), .IW(IW)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ack_clr_i (ack_clr),
        .ack_idx_i (acc_idx_o),
        .pend_o    (pend_q),
        .lvl_o     (lvl_q)
    );

    irqpc_arbiter #(
        .N(N), .LVL_W(LVL_W), .IW(IW)
    ) u_arb (
        .pend_i    (pend_q),
        .lvl_i     (lvl_q),
        .gie_i     (gie_q),
        .ipl_i     (ipl_q),
        .win_vld_o (win_vld),
        .win_idx_o (win_idx),
        .win_lvl_o (win_lvl)
    );

    irqpc_fsm #(
        .IW(IW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_vld_i (win_vld),
        .win_idx_i (win_idx),
        .ack_i     (ack_i),
        .accept_o  (accept_o),
        .idx_o     (acc_idx_o),
        .clr_o     (ack_clr)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == A_GIE) begin
            rd_data_o[0] = gie_q;
        end else if (rd_addr_i == A_IPL) begin
            rd_data_o[LVL_W-1:0] = ipl_q;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (rd_addr_i == AW'(i)) begin
                    rd_data_o[LVL_W]     = pend_q[i];
                    rd_data_o[LVL_W-1:0] = lvl_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/irqpc_checker.sv
module irqpc_checker #(
    parameter int N     = 8,
    parameter int LVL_W = 3,
    parameter int IW    = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N-1:0]            irq_i,
    input logic                    ack_i,
    input logic                    accept_o,
    input logic [IW-1:0]           acc_idx_o,
    input logic                    gie_q,
    input logic [LVL_W-1:0]        ipl_q,
    input logic [N-1:0]            pend_q,
    input logic [LVL_W-1:0]        win_lvl
);
    assert_accept_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> $past(gie_q));

    assert_level_above_ipl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept_o) |-> ($past(win_lvl) > $past(ipl_q)));

    assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !ack_i) |=> (accept_o && $stable(acc_idx_o)));

    assert_ack_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && ack_i) |=> !accept_o);

    for (genvar i = 0; i < N; i++) begin : g_src
        assert_sw_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !irq_i[i]) |=> !pend_q[i]);

        assert_hw_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq_i[i] |=> pend_q[i]);

        assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (accept_o && ack_i && acc_idx_o == IW'(i) && !irq_i[i]) |=> !pend_q[i]);
    end
endmodule

bind irq_prio_ctrl irqpc_checker #(
    .N(N), .LVL_W(LVL_W), .IW(IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_i),
    .ack_i     (ack_i),
    .accept_o  (accept_o),
    .acc_idx_o (acc_idx_o),
    .gie_q     (gie_q),
    .ipl_q     (ipl_q),
    .pend_q    (pend_q),
    .win_lvl   (win_lvl)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/100ps
module irq_prio_ctrl_tb;
    localparam int N     = 8;
    localparam int LVL_W = 3;
    localparam int DW    = 8;
    localparam int AW    = $clog2(N + 2);
    localparam int IW    = $clog2(N);
    localparam logic [AW-1:0] A_GIE = AW'(N);
    localparam logic [AW-1:0] A_IPL = AW'(N + 1);
    localparam int WD_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_i = '0;
    logic          wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          accept_o;
    logic [IW-1:0] acc_idx_o;
    logic          ack_i = 1'b0;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic             pend_m [N];
    logic [LVL_W-1:0] lvl_m  [N];
    logic             gie_m = 1'b0;
    logic [LVL_W-1:0] ipl_m = '0;
    logic             acc_m = 1'b0;
    logic [IW-1:0]    idx_m = '0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.N(N), .LVL_W(LVL_W), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .accept_o  (accept_o),
        .acc_idx_o (acc_idx_o),
        .ack_i     (ack_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        logic [DW-1:0] d = '0;
        if (a == A_GIE) d[0] = gie_m;
        else if (a == A_IPL) d[LVL_W-1:0] = ipl_m;
        else if (int'(a) < N) begin
            d[LVL_W]     = pend_m[a];
            d[LVL_W-1:0] = lvl_m[a];
        end
        return d;
    endfunction

    // one rising edge of the reference model, from the requirements
    task automatic model_edge(input logic [N-1:0] irq, input logic we,
                              input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                              input logic ack);
        logic             n_acc = acc_m;
        logic [IW-1:0]    n_idx = idx_m;
        logic             ack_clr = 1'b0;
        logic             found = 1'b0;
        logic [LVL_W-1:0] best = '0;
        if (!acc_m) begin
            for (int i = 0; i < N; i++) begin
                if (gie_m && pend_m[i] && lvl_m[i] > ipl_m && (!found || lvl_m[i] > best)) begin
                    found = 1'b1;
                    best  = lvl_m[i];
                    n_idx = IW'(i);
                end
            end
            n_acc = found;
        end else if (ack) begin
            n_acc   = 1'b0;
            ack_clr = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            logic clr;
            clr = (we && wa == AW'(i) && !wd[LVL_W]) || (ack_clr && idx_m == IW'(i));
            if (irq[i]) pend_m[i] = 1'b1;
            else if (clr) pend_m[i] = 1'b0;
            if (we && wa == AW'(i)) lvl_m[i] = wd[LVL_W-1:0];
        end
        if (we && wa == A_GIE) gie_m = wd[0];
        if (we && wa == A_IPL) ipl_m = wd[LVL_W-1:0];
        acc_m = n_acc;
        idx_m = n_idx;
    endtask

    task automatic step(input logic [N-1:0] irq, input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic ack, input logic [AW-1:0] ra,
                        input string tag);
        irq_i     = irq;
        wr_en_i   = we;
        wr_addr_i = wa;
        wr_data_i = wd;
        ack_i     = ack;
        rd_addr_i = ra;
        @(posedge clk);
        model_edge(irq, we, wa, wd, ack);
        @(negedge clk);
        irq_i   = '0;
        wr_en_i = 1'b0;
        ack_i   = 1'b0;
        chk(accept_o == acc_m, {tag, " accept"}, int'(accept_o), int'(acc_m));
        if (acc_m) chk(acc_idx_o == idx_m, {tag, " index"}, int'(acc_idx_o), int'(idx_m));
        chk(rd_data_o == exp_rd(ra), {tag, " read"}, int'(rd_data_o), int'(exp_rd(ra)));
    endtask

    task automatic idle(input logic [AW-1:0] ra, input string tag);
        step('0, 1'b0, '0, '0, 1'b0, ra, tag);
    endtask

    task automatic wr(input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic [AW-1:0] ra,
                      input string tag);
        step('0, 1'b1, wa, wd, 1'b0, ra, tag);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            pend_m[i] = 1'b0;
            lvl_m[i]  = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(accept_o == 1'b0, "R1 accept in reset", int'(accept_o), 0);
        rst_n = 1'b1;

        // R1: reset values read back
        idle(A_GIE, "R1");
        idle(A_IPL, "R1");
        idle(AW'(0), "R1");

        // R2: hardware request sets pending; R5: enable still 0
        step(N'(1) << 2, 1'b0, '0, '0, 1'b0, AW'(2), "R2");
        wr(AW'(2), 8'h0D, AW'(2), "R5");
        idle(AW'(2), "R5");
        idle(AW'(2), "R5");

        // R3: clear by writing 0, writing 1 never sets
        wr(AW'(2), 8'h05, AW'(2), "R3");
        wr(AW'(2), 8'h0D, AW'(2), "R3");
        idle(AW'(2), "R3");

        // R4: hardware set beats software clear in the same cycle
        step(N'(1) << 2, 1'b1, AW'(2), 8'h05, 1'b0, AW'(2), "R4");

        // R10: global registers leave the source word untouched
        wr(A_IPL, 8'h07, AW'(2), "R10");
        wr(A_GIE, 8'h01, AW'(2), "R10");
        idle(A_IPL, "R10");

        // R6: priority 7 blocks, equal level blocks, lower priority admits
        idle(A_GIE, "R6");
        wr(A_IPL, 8'h05, AW'(2), "R6");
        idle(AW'(2), "R6");
        wr(A_IPL, 8'h04, AW'(2), "R6");
        idle(AW'(2), "R6");

        // R8: grant is held while a higher source arrives
        wr(AW'(5), 8'h07, AW'(5), "R8");
        step(N'(1) << 5, 1'b0, '0, '0, 1'b0, AW'(5), "R8");
        idle(AW'(5), "R8");
        wr(A_GIE, 8'h00, AW'(2), "R8");
        wr(A_GIE, 8'h01, AW'(2), "R8");

        // R9: acknowledge clears source 2 and the next winner follows
        step('0, 1'b0, '0, '0, 1'b1, AW'(2), "R9");
        idle(AW'(5), "R9");

        // R11: request on the acknowledged source keeps it pending
        step(N'(1) << 5, 1'b0, '0, '0, 1'b1, AW'(5), "R11");
        idle(AW'(5), "R11");
        step('0, 1'b0, '0, '0, 1'b1, AW'(5), "R11");

        // R7: tie on level resolved to the lower index, then the other
        wr(AW'(1), 8'h06, AW'(1), "R7");
        wr(AW'(4), 8'h06, AW'(4), "R7");
        wr(AW'(0), 8'h01, AW'(0), "R7");
        step(N'(8'h13), 1'b0, '0, '0, 1'b0, AW'(1), "R7");
        idle(AW'(4), "R7");
        step('0, 1'b0, '0, '0, 1'b1, AW'(1), "R7");
        idle(AW'(4), "R7");
        step('0, 1'b0, '0, '0, 1'b1, AW'(4), "R7");
        idle(AW'(0), "R7");
        step('0, 1'b0, '0, '0, 1'b1, AW'(0), "R7");

        // R9: acknowledge with nothing accepted is ignored
        wr(A_GIE, 8'h00, A_GIE, "R9");
        step(N'(1) << 3, 1'b0, '0, '0, 1'b1, AW'(3), "R9");
        step('0, 1'b0, '0, '0, 1'b1, AW'(3), "R9");

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0]  r_irq;
            logic          r_we;
            logic [AW-1:0] r_wa;
            logic [DW-1:0] r_wd;
            logic          r_ack;
            logic [AW-1:0] r_ra;
            r_irq = N'($urandom & $urandom & $urandom);
            r_we  = ($urandom % 4) == 0;
            r_wa  = AW'($urandom % (N + 2));
            r_wd  = DW'($urandom);
            r_ack = ($urandom % 3) == 0;
            r_ra  = AW'($urandom % (N + 2));
            step(r_irq, r_we, r_wa, r_wd, r_ack, r_ra, "R7 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule